// File: doc/BRIEF.md
# Serial EEPROM Device Model (three-wire command, 16-bit words)

This block is a synthesizable stand-in for a small serial EEPROM. It sits on the device side of a chip-select, serial-clock, data-in and data-out link. It holds its words in an internal register array, so that host logic that boots from or stores settings in such a memory can be exercised in simulation and emulation without a real part. The whole model runs on one fast system clock. It samples the slow serial clock and acts on each rising edge of that clock.

A host raises chip-select and shifts in a command, MSB first. A command is a 1 start bit, a 2-bit opcode, the address and, for the two data-carrying commands, a 16-bit word. Reads answer at once on data-out. Programming commands take effect when chip-select falls, and only while writes are enabled. The host then raises chip-select again and watches data-out, which stays low until the modelled programming time, counted in system clocks, has run out.

Top module: `mw_serial_eeprom`

## Requirements
- R1: Zero bits clocked in while idle are skipped. The first 1 is the start bit. It is followed by a 2-bit opcode, then ADDR_W address bits MSB first, then 16 data bits MSB first for the write and write-all commands.
- R2: Opcode 2'b10 reads. On the rising serial-clock edge that carries the last address bit, data-out goes to 0. Each of the next 16 rising edges presents the next bit of the stored word, MSB first. Every further edge gives 1.
- R3: Opcode 2'b01 stores the 16 data bits at the addressed word.
- R4: Opcode 2'b11 sets the addressed word to 16'hFFFF.
- R5: Opcode 2'b00 is picked apart by the two top address bits. 2'b11 enables writes, 2'b00 disables writes, 2'b10 sets every word to 16'hFFFF, and 2'b01 stores the following 16-bit word in every word. The lower address bits are ignored.
- R6: Write, erase, erase-all and write-all do nothing unless writes are enabled. A rejected command leaves no busy period.
- R7: An accepted programming command takes effect on the falling edge of chip-select. While chip-select is high and no command is in progress, data-out is low for BUSY_CYCLES system clocks and then high.
- R8: A command whose first bit arrives while busy is ignored in full, up to the next chip-select fall.
- R9: Dropping chip-select returns the device to idle and throws away a half-received command. Data-out is high while chip-select is low, and a serial-clock edge in the same cycle as the fall is ignored.
- R10: After reset every word reads 16'hFFFF, writes are disabled and the device is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial clock is sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip-select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data to the host: read bits or ready/busy status, high when idle |

## Verification
Two events can land in the same system cycle. The first is the chip-select fall that commits a programming command, which comes with a rising serial-clock edge. Every command the bench sends ends this way, and the bench checks that the edge is neither decoded nor able to upset the commit. The second is the busy window against a new start bit: a write is issued right after another, so its first bit arrives while busy. The bench judges it by reading back the untouched word and by the length of the ready/busy wait.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WRITE,
    CMD_ERASE,
    CMD_ERAL,
    CMD_WRAL,
    CMD_EWEN,
    CMD_EWDS
  } mw_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_READ,
    ST_HOLD,
    ST_SKIP
  } mw_state_e;

  // two top address bits select the extended command under opcode 2'b00
  function automatic mw_cmd_e ext_decode(input logic [1:0] sel);
    case (sel)
      2'b11:   return CMD_EWEN;
      2'b10:   return CMD_ERAL;
      2'b01:   return CMD_WRAL;
      default: return CMD_EWDS;
    endcase
  endfunction

  function automatic logic is_prog(input mw_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_ERAL) || (c == CMD_WRAL);
  endfunction

endpackage

// File: rtl/mw_edge_detect.sv
module mw_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  output logic sk_rise
);

  logic sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end

  assign sk_rise = sk & ~sk_q;

endmodule

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk_rise,
  input  logic              di,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              commit,
  output mw_cmd_e           commit_cmd,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              in_read,
  output logic              at_status,
  output logic              dout_bit
);

  localparam int HDR_W = ADDR_W + 2;
  localparam int MAXF  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXF + 1);

  mw_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HDR_W-1:0]  hdr_q, hdr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [DATA_W:0]   out_q, out_d;
  mw_cmd_e           cmd_q, cmd_d;
  logic [HDR_W-1:0]  hdr_full;
  mw_cmd_e           ext_cmd;

  assign hdr_full = {hdr_q[HDR_W-2:0], di};
  assign rd_addr  = hdr_full[ADDR_W-1:0];
  assign ext_cmd  = ext_decode(hdr_full[ADDR_W-1:ADDR_W-2]);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hdr_d   = hdr_q;
    data_d  = data_q;
    out_d   = out_q;
    cmd_d   = cmd_q;
    commit  = 1'b0;
    if (!cs) begin
      state_d = ST_IDLE;
      commit  = (state_q == ST_HOLD) && (cmd_q != CMD_NONE);
    end else if (sk_rise) begin
      case (state_q)
        ST_IDLE: begin
          if (busy) begin
            state_d = ST_SKIP;
          end else if (di) begin
            state_d = ST_HDR;
            cnt_d   = '0;
            cmd_d   = CMD_NONE;
          end
        end
        ST_HDR: begin
          hdr_d = hdr_full;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_W - 1)) begin
            cnt_d = '0;
            case (hdr_full[HDR_W-1:HDR_W-2])
              2'b10: begin
                state_d = ST_READ;
                out_d   = {1'b0, rd_data};
              end
              2'b01: begin
                cmd_d   = CMD_WRITE;
                state_d = ST_DATA;
              end
              2'b11: begin
                cmd_d   = CMD_ERASE;
                state_d = ST_HOLD;
              end
              default: begin
                cmd_d   = ext_cmd;
                state_d = (ext_cmd == CMD_WRAL) ? ST_DATA : ST_HOLD;
              end
            endcase
          end
        end
        ST_DATA: begin
          data_d = {data_q[DATA_W-2:0], di};
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) state_d = ST_HOLD;
        end
        ST_READ: out_d = {out_q[DATA_W-1:0], 1'b1};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      data_q  <= '0;
      out_q   <= '1;
      cmd_q   <= CMD_NONE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hdr_q   <= hdr_d;
      data_q  <= data_d;
      out_q   <= out_d;
      cmd_q   <= cmd_d;
    end
  end

  assign commit_cmd  = cmd_q;
  assign commit_addr = hdr_q[ADDR_W-1:0];
  assign commit_data = data_q;
  assign in_read     = (state_q == ST_READ);
  assign at_status   = (state_q == ST_IDLE) || (state_q == ST_SKIP);
  assign dout_bit    = out_q[DATA_W];

  // R9
  cs_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (state_q == ST_IDLE));

  // R8
  busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sk_rise && busy && state_q == ST_IDLE) |=> (state_q == ST_SKIP));

  // R2
  read_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sk_rise && state_q == ST_READ) |=> out_q[0]);

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  mw_cmd_e           cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);

  logic                          we_q, we_d;
  logic [BCNT_W-1:0]             bcnt_q, bcnt_d;
  logic                          prog_go, one_sel, all_sel;
  logic [DATA_W-1:0]             wr_val;
  logic [DEPTH-1:0][DATA_W-1:0]  words;

  assign busy    = (bcnt_q != '0);
  assign prog_go = commit && we_q && is_prog(cmd) && !busy;
  assign one_sel = prog_go && ((cmd == CMD_WRITE) || (cmd == CMD_ERASE));
  assign all_sel = prog_go && ((cmd == CMD_ERAL) || (cmd == CMD_WRAL));
  assign wr_val  = ((cmd == CMD_WRITE) || (cmd == CMD_WRAL)) ? data : '1;

  always_comb begin
    we_d = we_q;
    if (commit && cmd == CMD_EWEN) we_d = 1'b1;
    if (commit && cmd == CMD_EWDS) we_d = 1'b0;
    bcnt_d = bcnt_q;
    if (prog_go)   bcnt_d = BCNT_W'(BUSY_CYCLES);
    else if (busy) bcnt_d = bcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      bcnt_q <= '0;
    end else begin
      we_q   <= we_d;
      bcnt_q <= bcnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_q;
    assign hit = all_sel || (one_sel && (addr == ADDR_W'(gi)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '1;
      else if (hit) word_q <= wr_val;
    end
    assign words[gi] = word_q;
  end

  assign rd_data = words[rd_addr];

  // R7
  prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && we_q && !busy && cmd == CMD_WRITE) |=> busy);

  // R6
  no_enable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !we_q && !busy) |=> !busy);

  // R7
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (bcnt_q == $past(bcnt_q) - 1'b1));

  // R5
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd == CMD_EWEN) |=> we_q);

endmodule

// File: rtl/mw_serial_eeprom.sv
module mw_serial_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o
);

  logic              sk_rise;
  logic              busy;
  logic              commit;
  mw_cmd_e           commit_cmd;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              in_read, at_status, dout_bit;

  mw_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sk      (sk),
    .sk_rise (sk_rise)
  );

  mw_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs          (cs),
    .sk_rise     (sk_rise),
    .di          (di),
    .busy        (busy),
    .rd_data     (rd_data),
    .rd_addr     (rd_addr),
    .commit      (commit),
    .commit_cmd  (commit_cmd),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .in_read     (in_read),
    .at_status   (at_status),
    .dout_bit    (dout_bit)
  );

  mw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .cmd     (commit_cmd),
    .addr    (commit_addr),
    .data    (commit_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .busy    (busy)
  );

  always_comb begin
    if (!cs)            do_o = 1'b1;
    else if (in_read)   do_o = dout_bit;
    else if (at_status) do_o = ~busy;
    else                do_o = 1'b1;
  end

  // R10
  reset_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy);

endmodule

// File: tb/tb_mw_serial_eeprom.sv
module tb_mw_serial_eeprom;

  localparam int AW    = 6;
  localparam int NW    = 1 << AW;
  localparam int BUSY  = 48;

  logic clk, rst_n, cs, sk, di;
  logic do_o;
  int   checks   = 0;
  int   failures = 0;
  logic [15:0] exp_mem [NW];

  mw_serial_eeprom #(.ADDR_W(AW), .DATA_W(16), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    di = b; sk = 1'b0; tick(2);
    sk = 1'b1; tick(2);
  endtask

  task automatic cs_on();
    cs = 1'b1; tick(2);
  endtask

  // chip-select falls in the same cycle as a serial-clock rise (R9)
  task automatic cs_off();
    sk = 1'b0; tick(2);
    cs = 1'b0; sk = 1'b1; di = 1'b1; tick(2);
    sk = 1'b0; di = 1'b0; tick(2);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = AW-1; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] w);
    cs_on(); send_hdr(2'b01, a); send_word(w); cs_off();
  endtask

  task automatic do_ext(input logic [1:0] sel, input logic has_data, input logic [15:0] w);
    cs_on(); send_hdr(2'b00, {sel, {(AW-2){1'b0}}}); if (has_data) send_word(w); cs_off();
  endtask

  task automatic wait_ready(output int n);
    cs_on();
    n = 0;
    while (do_o == 1'b0 && n < 2000) begin tick(1); n++; end
    cs_off();
  endtask

  task automatic read_word(input logic [AW-1:0] a, input int lead,
                           output logic dummy, output logic [15:0] w, output logic tail);
    cs_on();
    for (int i = 0; i < lead; i++) send_bit(1'b0);
    send_hdr(2'b10, a);
    dummy = do_o;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      sk = 1'b0; tick(2); sk = 1'b1; tick(2);
      w = {w[14:0], do_o};
    end
    sk = 1'b0; tick(2); sk = 1'b1; tick(2);
    tail = do_o;
    cs_off();
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0409) ^ 16'hA5C3;
  endfunction

  task automatic read_chk(input int a, input string req);
    logic d, t;
    logic [15:0] w;
    read_word(AW'(a), 0, d, w, t);
    chk(w == exp_mem[a], req, int'(w), int'(exp_mem[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic d, t;
    logic [15:0] w;
    int n;
    cs = 1'b0; sk = 1'b0; di = 1'b0; rst_n = 1'b0;
    for (int a = 0; a < NW; a++) exp_mem[a] = 16'hFFFF;
    tick(4);
    rst_n = 1'b1;
    tick(2);

    // R10: reset state
    chk(do_o == 1'b1, "R10 do high after reset", int'(do_o), 1);
    read_word(6'd0, 0, d, w, t);
    chk(w == 16'hFFFF, "R10 word erased after reset", int'(w), 16'hFFFF);
    // R2: read framing
    chk(d == 1'b0, "R2 dummy zero", int'(d), 0);
    chk(t == 1'b1, "R2 high after last bit", int'(t), 1);

    // R6: write disabled after reset (R10)
    do_write(6'd5, 16'h1234);
    wait_ready(n);
    chk(n == 0, "R6 no busy when disabled", n, 0);
    read_chk(5, "R6 word kept when disabled");

    // R5: enable, then R3/R7 exhaustive write sweep
    do_ext(2'b11, 1'b0, 16'h0);
    for (int a = 0; a < NW; a++) begin
      do_write(AW'(a), pat(a));
      exp_mem[a] = pat(a);
      wait_ready(n);
      if (a == 0 || a == NW-1)
        chk(n >= BUSY-6 && n <= BUSY-4, "R7 busy length", n, BUSY-5);
      else
        chk(n > 0 && n < BUSY, "R7 busy seen", n, BUSY-5);
    end
    for (int a = 0; a < NW; a++) read_chk(a, "R3 write sweep readback");

    // R1: leading zeros before the start bit
    read_word(6'd33, 3, d, w, t);
    chk(w == exp_mem[33], "R1 leading zeros skipped", int'(w), int'(exp_mem[33]));

    // R4: single erase
    cs_on(); send_hdr(2'b11, 6'd7); cs_off();
    exp_mem[7] = 16'hFFFF;
    wait_ready(n);
    chk(n > 0, "R4 erase busy", n, BUSY-5);
    read_chk(7, "R4 erased word");
    read_chk(8, "R4 neighbour kept");

    // R8: second write starts while busy
    do_write(6'd9, 16'h0F0F);
    exp_mem[9] = 16'h0F0F;
    do_write(6'd10, 16'hBEEF);
    wait_ready(n);
    chk(n == 0, "R8 no busy from ignored write", n, 0);
    read_chk(9, "R8 first write done");
    read_chk(10, "R8 busy write ignored");

    // R9: abort mid data
    cs_on(); send_hdr(2'b01, 6'd12);
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    cs = 1'b0; tick(2);
    chk(do_o == 1'b1, "R9 do high with cs low", int'(do_o), 1);
    cs_off();
    wait_ready(n);
    chk(n == 0, "R9 aborted write not busy", n, 0);
    read_chk(12, "R9 aborted write ignored");

    // R5: erase-all, write-all
    do_ext(2'b10, 1'b0, 16'h0);
    wait_ready(n);
    for (int a = 0; a < NW; a++) exp_mem[a] = 16'hFFFF;
    read_chk(3, "R5 erase-all");
    read_chk(40, "R5 erase-all");
    do_ext(2'b01, 1'b1, 16'h1357);
    wait_ready(n);
    chk(n > 0, "R5 write-all busy", n, BUSY-5);
    for (int a = 0; a < NW; a++) exp_mem[a] = 16'h1357;
    for (int a = 0; a < NW; a++) read_chk(a, "R5 write-all sweep");

    // R6: disable, then programming is rejected
    do_ext(2'b00, 1'b0, 16'h0);
    do_write(6'd11, 16'h0000);
    wait_ready(n);
    chk(n == 0, "R6 disabled write not busy", n, 0);
    read_chk(11, "R6 disabled write ignored");
    do_ext(2'b10, 1'b0, 16'h0);
    read_chk(20, "R6 disabled erase-all ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule